// File: doc/BRIEF.md
# Five-Bit Teaching Processor Core

This block is a very small processor intended for classroom use. It runs up to eight fixed-width 8-bit instructions held in an internal program store, and works on two 5-bit two's-complement registers, A and C. Only four operations exist: load an immediate, add an immediate, jump relative when C is negative, and stop. Each instruction passes through three visible internal states: fetch, decode and execute. A stopped core stays stopped until reset.

The program store is filled through a simple write port. That port is honoured only while reset is held or the core has stopped. The core then either runs freely, advancing one state per clock, or is single-stepped. In single-step mode each rising edge of the step input advances exactly one internal state. The registers, the program counter and the stop flag are driven straight out, so a panel of lamps can show them.

The sequencer states are FETCH, DECODE, EXEC and HALT. Reset always lands in FETCH. On an advance, FETCH moves to DECODE, DECODE moves to EXEC, and EXEC moves to FETCH, or to HALT when the instruction stops the core. HALT only leaves on reset. Without an advance the state holds.

Top module: `mini5_cpu`

## Requirements
- R1: An instruction word has the operation code in bits 7:6, the register select in bit 5 (0 = register A, 1 = register C) and a 5-bit two's-complement immediate in bits 4:0. Bit 5 has no effect on a jump.
- R2: Code 00 copies the immediate into the selected register and moves the program counter to the next address.
- R3: Code 01 adds the immediate to the selected register modulo 32. No carry or overflow is kept. A negative immediate therefore subtracts.
- R4: Code 10 tests bit 4 of register C. When that bit is 1, the program counter becomes the jump's own address plus the sign-extended immediate, modulo 8. Otherwise it moves to the next address. Neither register changes.
- R5: Code 11 with bits 5:0 all zero stops the core: the stop flag rises and the program counter stays on that instruction. Code 11 with any other low bits only advances the program counter.
- R6: Once stopped, the core keeps the stop flag, the program counter and both registers unchanged until reset.
- R7: A synchronous reset clears the program counter, both registers and the stop flag. It leaves the program store contents intact.
- R8: A write on the load port lands in the program store only in a cycle where reset or the stop flag is high. At any other time it is ignored.
- R9: In free-run mode every instruction takes exactly three clock edges. Its register and program-counter results appear after the third edge and not before.
- R10: In single-step mode the core advances one state per rising edge of the step input, however long the input stays high. Without such an edge the state and all outputs hold.
- R11: Sequential execution past address 7 continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | 3 | Program store write address |
| prog_data | input | 8 | Instruction word to write |
| step_mode | input | 1 | 1 = single-step, 0 = free run |
| step_in | input | 1 | Step request, acted on at its rising edge |
| ax_o | output | 5 | Register A |
| cx_o | output | 5 | Register C |
| pc_o | output | 3 | Program counter |
| halted_o | output | 1 | Stop flag |

## Verification
Loading the program store and executing instructions are the two functions that can meet in one cycle. The bench provokes this by firing a load-port write while a non-stopping program is running, and again right after a stop instruction has taken effect. It judges the outcome only through later execution. After a reset, a program that counts in register A must give the same count that the untouched store would give, which shows the write made while running had no effect. A write made while stopped must change what the next run produces. Around this, the bench sweeps every pair of immediates through the load and add operations, and every value of C against every jump offset. It compares the visible state with an instruction-level model written in the bench.

// File: rtl/mini5_pkg.sv
package mini5_pkg;

    // Operation codes carried in the two top bits of an instruction.
    typedef enum logic [1:0] {
        OP_MOV  = 2'b00,
        OP_ADD  = 2'b01,
        OP_JNEG = 2'b10,
        OP_SYS  = 2'b11
    } op_e;

    // Sequencer states; three per instruction plus the terminal one.
    typedef enum logic [1:0] {
        ST_FETCH  = 2'b00,
        ST_DECODE = 2'b01,
        ST_EXEC   = 2'b10,
        ST_HALT   = 2'b11
    } state_e;

    localparam int OP_W  = 2;
    localparam int SEL_W = 1;

endpackage

// File: rtl/mini5_store.sv
module mini5_store #(
    parameter int AW = 3,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic          allow_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [IW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [IW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [IW-1:0] mem [DEPTH];

    // No reset: the contents must survive a core reset (R7).
    always_ff @(posedge clk) begin
        if (we_i && allow_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/mini5_step.sv
module mini5_step (
    input  logic clk,
    input  logic rst,
    input  logic mode_i,
    input  logic step_i,
    output logic adv_o
);
    logic step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= 1'b0;
        end else begin
            step_q <= step_i;
        end
    end

    always_comb begin
        if (mode_i) begin
            adv_o = step_i & ~step_q;
        end else begin
            adv_o = 1'b1;
        end
    end

    // R10: an advance in single-step mode is never followed by another one
    // in the next cycle while single-step mode stays on.
    assert_one_per_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_i && adv_o) |=> !(mode_i && adv_o));

endmodule

// File: rtl/mini5_exec.sv
module mini5_exec
    import mini5_pkg::*;
#(
    parameter int DW = 5,
    parameter int AW = 3
) (
    input  op_e           op_i,
    input  logic          sel_i,
    input  logic [DW-1:0] imm_i,
    input  logic [DW-1:0] ax_i,
    input  logic [DW-1:0] cx_i,
    input  logic [AW-1:0] pc_i,
    output logic [DW-1:0] ax_o,
    output logic [DW-1:0] cx_o,
    output logic [AW-1:0] pc_o,
    output logic          halt_o
);
    logic [AW-1:0] offset;
    logic [AW-1:0] pc_seq;
    logic [DW-1:0] sum;
    logic [DW-1:0] target_val;

    // The jump offset, brought to program-counter width. Wrapping is
    // implicit in the fixed width of the sum.
    generate
        if (AW <= DW) begin : g_trunc
            assign offset = imm_i[AW-1:0];
        end else begin : g_sext
            assign offset = {{(AW-DW){imm_i[DW-1]}}, imm_i};
        end
    endgenerate

    assign pc_seq = pc_i + AW'(1);
    assign sum    = (sel_i ? cx_i : ax_i) + imm_i;

    always_comb begin
        ax_o       = ax_i;
        cx_o       = cx_i;
        pc_o       = pc_seq;
        halt_o     = 1'b0;
        target_val = imm_i;
        unique case (op_i)
            OP_MOV: target_val = imm_i;
            OP_ADD: target_val = sum;
            OP_JNEG: begin
                if (cx_i[DW-1]) begin
                    pc_o = pc_i + offset;
                end
            end
            OP_SYS: begin
                if (!sel_i && (imm_i == '0)) begin
                    halt_o = 1'b1;
                    pc_o   = pc_i;
                end
            end
        endcase
        if ((op_i == OP_MOV) || (op_i == OP_ADD)) begin
            if (sel_i) begin
                cx_o = target_val;
            end else begin
                ax_o = target_val;
            end
        end
    end

endmodule

// File: rtl/mini5_cpu.sv
module mini5_cpu
    import mini5_pkg::*;
#(
    parameter int DW = 5,
    parameter int AW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_we,
    input  logic [AW-1:0]    prog_addr,
    input  logic [DW+2:0]    prog_data,
    input  logic             step_mode,
    input  logic             step_in,
    output logic [DW-1:0]    ax_o,
    output logic [DW-1:0]    cx_o,
    output logic [AW-1:0]    pc_o,
    output logic             halted_o
);
    localparam int IW = OP_W + SEL_W + DW;

    state_e        state_q, state_d;
    logic          adv;
    logic [IW-1:0] rd_word;
    logic [IW-1:0] ir_q;
    op_e           op_q;
    logic          sel_q;
    logic [DW-1:0] imm_q;
    logic [DW-1:0] ax_q, cx_q, ax_n, cx_n;
    logic [AW-1:0] pc_q, pc_n;
    logic          halted_q, halt_n;

    mini5_store #(.AW(AW), .IW(IW)) u_store (
        .clk     (clk),
        .we_i    (prog_we),
        .allow_i (rst | halted_q),
        .waddr_i (prog_addr),
        .wdata_i (prog_data),
        .raddr_i (pc_q),
        .rdata_o (rd_word)
    );

    mini5_step u_step (
        .clk    (clk),
        .rst    (rst),
        .mode_i (step_mode),
        .step_i (step_in),
        .adv_o  (adv)
    );

    mini5_exec #(.DW(DW), .AW(AW)) u_exec (
        .op_i   (op_q),
        .sel_i  (sel_q),
        .imm_i  (imm_q),
        .ax_i   (ax_q),
        .cx_i   (cx_q),
        .pc_i   (pc_q),
        .ax_o   (ax_n),
        .cx_o   (cx_n),
        .pc_o   (pc_n),
        .halt_o (halt_n)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                ST_FETCH:  state_d = ST_DECODE;
                ST_DECODE: state_d = ST_EXEC;
                ST_EXEC:   state_d = halt_n ? ST_HALT : ST_FETCH;
                ST_HALT:   state_d = ST_HALT;
            endcase
        end
    end

    // Per-state register updates.
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q     <= '0;
            op_q     <= OP_MOV;
            sel_q    <= 1'b0;
            imm_q    <= '0;
            ax_q     <= '0;
            cx_q     <= '0;
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else if (adv) begin
            unique case (state_q)
                ST_FETCH: begin
                    ir_q <= rd_word;
                end
                ST_DECODE: begin
                    op_q  <= op_e'(ir_q[IW-1 -: OP_W]);
                    sel_q <= ir_q[DW];
                    imm_q <= ir_q[DW-1:0];
                end
                ST_EXEC: begin
                    ax_q     <= ax_n;
                    cx_q     <= cx_n;
                    pc_q     <= pc_n;
                    halted_q <= halt_n;
                end
                ST_HALT: begin
                    halted_q <= 1'b1;
                end
            endcase
        end
    end

    assign ax_o     = ax_q;
    assign cx_o     = cx_q;
    assign pc_o     = pc_q;
    assign halted_o = halted_q;

    // R7: reset leaves the visible state cleared.
    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && ax_q == '0 && cx_q == '0 && !halted_q));

    // R6: the stop flag is sticky.
    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> halted_q);

    // R6: nothing visible moves once stopped.
    assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> ($stable(pc_q) && $stable(ax_q) && $stable(cx_q)));

    // R9: visible results change only on an executing advance.
    assert_exec_only_R9: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_EXEC && adv) |=> ($stable(ax_q) && $stable(cx_q) && $stable(pc_q)));

    // R10: without an advance the sequencer holds.
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q));

endmodule

// File: tb/mini5_cpu_tb.sv
module mini5_cpu_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [2:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic       step_mode = 1'b0;
    logic       step_in = 1'b0;
    logic [4:0] ax_o, cx_o;
    logic [2:0] pc_o;
    logic       halted_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] prog [8];
    int m_ax, m_cx, m_pc, m_h;

    always #(CLK_PERIOD/2) clk = ~clk;

    mini5_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .step_mode (step_mode),
        .step_in   (step_in),
        .ax_o      (ax_o),
        .cx_o      (cx_o),
        .pc_o      (pc_o),
        .halted_o  (halted_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Instruction-level model built from the requirements.
    task automatic model_run(input int n);
        logic [7:0] w;
        int imm;
        m_ax = 0; m_cx = 0; m_pc = 0; m_h = 0;
        for (int i = 0; i < n; i++) begin
            if (m_h != 0) break;
            w = prog[m_pc];
            imm = int'(w[4:0]);
            if (imm >= 16) imm -= 32;
            case (w[7:6])
                2'b00: begin
                    if (w[5]) m_cx = (imm + 32) % 32; else m_ax = (imm + 32) % 32;
                    m_pc = (m_pc + 1) % 8;
                end
                2'b01: begin
                    if (w[5]) m_cx = (m_cx + imm + 32) % 32; else m_ax = (m_ax + imm + 32) % 32;
                    m_pc = (m_pc + 1) % 8;
                end
                2'b10: begin
                    if (m_cx >= 16) m_pc = ((m_pc + imm) % 8 + 8) % 8;
                    else m_pc = (m_pc + 1) % 8;
                end
                default: begin
                    if (w[5:0] == 6'd0) m_h = 1;
                    else m_pc = (m_pc + 1) % 8;
                end
            endcase
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " ax"}, int'(ax_o), m_ax);
        chk({tag, " cx"}, int'(cx_o), m_cx);
        chk({tag, " pc"}, int'(pc_o), m_pc);
        chk({tag, " halted"}, int'(halted_o), m_h);
    endtask

    // Fill the store; reset is held across the writes when with_rst is set.
    task automatic load_prog(input bit with_rst);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            rst       = with_rst;
            prog_we   = 1'b1;
            prog_addr = 3'(a);
            prog_data = prog[a];
        end
        @(negedge clk);
        prog_we = 1'b0;
        rst     = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_instr(input int n);
        repeat (3 * n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int hold);
        @(negedge clk);
        step_in = 1'b1;
        repeat (hold) @(negedge clk);
        step_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Reset state (R7).
        for (int a = 0; a < 8; a++) prog[a] = 8'hC0;
        load_prog(1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 reset pc", int'(pc_o), 0);
        chk("R7 reset ax", int'(ax_o), 0);
        chk("R7 reset cx", int'(cx_o), 0);
        chk("R7 reset halted", int'(halted_o), 0);
        rst = 1'b0;

        // Counting loop: C from -5 up to 0 (R2 R3 R4 R5).
        prog[0] = 8'h00; prog[1] = 8'h3B; prog[2] = 8'h41; prog[3] = 8'h61;
        prog[4] = 8'h9E; prog[5] = 8'hC0; prog[6] = 8'h41; prog[7] = 8'h41;
        load_prog(1'b1);
        model_run(60);
        run_instr(60);
        compare_all("R4 R5 loop");
        chk("R3 loop count", int'(ax_o), 5);

        // Stopped state is frozen (R6).
        repeat (25) @(negedge clk);
        compare_all("R6 frozen");

        // Load while stopped takes effect (R8) and survives reset (R7).
        prog[0] = 8'h07; prog[1] = 8'hC0;
        for (int a = 2; a < 8; a++) prog[a] = 8'h41;
        load_prog(1'b0);
        restart();
        model_run(4);
        run_instr(4);
        compare_all("R8 R7 load while stopped");

        // Load while running is ignored (R8).
        for (int a = 0; a < 8; a++) prog[a] = 8'h41;
        load_prog(1'b1);
        run_instr(2);
        prog_we = 1'b1; prog_addr = 3'd0; prog_data = 8'hC0;
        @(negedge clk);
        prog_we = 1'b0;
        restart();
        run_instr(4);
        chk("R8 write while running ax", int'(ax_o), 4);
        chk("R8 write while running halted", int'(halted_o), 0);

        // Three-edge timing (R9).
        prog[0] = 8'h0D;
        load_prog(1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 no early result ax", int'(ax_o), 0);
        chk("R9 no early result pc", int'(pc_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 result after third edge ax", int'(ax_o), 13);
        chk("R9 result after third edge pc", int'(pc_o), 1);

        // Single-step (R10).
        prog[0] = 8'h05; prog[1] = 8'h29;
        step_mode = 1'b1;
        load_prog(1'b1);
        pulse(1);
        pulse(3);
        chk("R10 two steps ax", int'(ax_o), 0);
        chk("R10 two steps pc", int'(pc_o), 0);
        pulse(5);
        chk("R10 third step ax", int'(ax_o), 5);
        chk("R10 third step pc", int'(pc_o), 1);
        repeat (12) @(negedge clk);
        chk("R10 idle hold pc", int'(pc_o), 1);
        pulse(1); pulse(1);
        chk("R10 partial second cx", int'(cx_o), 0);
        pulse(2);
        chk("R10 second instr cx", int'(cx_o), 9);
        step_mode = 1'b0;

        // Load/add sweep over all immediate pairs (R1 R2 R3).
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                prog[0] = 8'h00 | 8'(a);
                prog[1] = 8'h40 | 8'(b);
                prog[2] = 8'h20 | 8'(b);
                prog[3] = 8'h60 | 8'(a);
                prog[4] = 8'hC0;
                load_prog(1'b1);
                model_run(5);
                run_instr(5);
                chk("R3 R1 add ax", int'(ax_o), m_ax);
                chk("R2 R1 move add cx", int'(cx_o), m_cx);
                chk("R5 halt pc", int'(pc_o), m_pc);
            end
        end

        // Jump sweep over every C value and offset (R1 R4 R5 R11).
        for (int v = 0; v < 32; v++) begin
            for (int off = 0; off < 32; off++) begin
                prog[0] = 8'h20 | 8'(v);
                prog[1] = 8'h43;
                prog[2] = 8'h80 | (8'(v & 1) << 5) | 8'(off);
                for (int a = 3; a < 7; a++) prog[a] = 8'h41;
                prog[7] = 8'hC5;
                load_prog(1'b1);
                model_run(9);
                run_instr(9);
                compare_all("R4 R1 R5 R11 jump");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule